// File: doc/BRIEF.md
# 2D Rectangle Copy and Fill Engine

This block is a register-programmed drawing engine for a byte-addressed frame buffer. Software programs a source corner, a destination corner, a rectangle size, two row pitches, a base address and a colour byte through a 32-bit register bus. It then writes a control word that either copies the source rectangle onto the destination rectangle or paints the destination rectangle with the colour byte. While an operation runs, the engine walks the rectangle one byte at a time over a single-port synchronous memory interface and raises a busy flag.

Copies between overlapping rectangles stay correct because the engine can also walk backwards. In backward mode the programmed corners are the bottom-right ones, and both addresses step downwards. Software picks the direction with a simple row and column comparison. Fill and copy share one control word. Horizontal quantities are in bytes, so a caller multiplies pixel counts by the bytes per pixel.

Top module: `blit2d_engine`

## Requirements
- R1: Registers sit at word index `reg_addr`: 0 source corner, 1 destination corner, 2 size, 3 pitches, 4 base address, 5 colour (bits 7:0), 6 control, 7 status. Corner and size registers pack X/width in bits 31:16 and Y/height in bits 15:0. The pitch register holds the source pitch in bits 15:0 and the destination pitch in bits 31:16. All of them read back what was written; `reg_rdata` is combinational from `reg_addr`.
- R2: A control write with bit 31 set starts an operation when the engine is idle, the command field (bits 19:16) is 0 (copy) or 1 (fill), and the size register already holds a nonzero width and height. `busy` is high from the next clock edge.
- R3: The byte address is base + Y × pitch + X, truncated to the address width. In forward mode X advances through a row and Y advances once per row, starting from the programmed top-left corners.
- R4: When control bit 27 is set, the programmed corners are bottom-right, and X and Y both step downwards with the same row-by-row order.
- R5: A copy reads one source byte and writes it to the destination in the following cycle. Each byte takes two cycles, so `busy` lasts 2 × W × H cycles.
- R6: A fill writes the colour byte to every destination byte position, one byte per cycle, so `busy` lasts W × H cycles.
- R7: While an operation runs, status bit 3 and control bit 31 read 1. Both read 0 from the cycle after the last byte has been written.
- R8: Register writes issued while `busy` is high change no register and do not affect the running operation.
- R9: A start request with zero width, zero height or a command other than 0 or 1 does nothing: it makes no memory access, `busy` stays low and control bit 31 reads 0.
- R10: With the direction chosen by the rule "backward when the source row is above the destination row, or the rows are equal and the source column is left of the destination column", a copy between overlapping rectangles produces the destination contents that the original source held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write (1) or a read (0) |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid the cycle after a read access |
| busy | output | 1 | Operation in progress |

## Verification
The hardest situation to reach is an overlapping copy in which a byte that has already been written is read back as source in the same operation. Only the traversal direction keeps this from corrupting the result. Random stimulus keeps rectangles small and places the source and destination within a few bytes of each other on a shared pitch, so most copies overlap. Directed cases shift a block by one byte right, down and up. Every result is compared with a bench model that snapshots the source before it writes, so a wrong direction or a wrong corner convention shows up as a memory mismatch.

// File: rtl/blit2d_pkg.sv
package blit2d_pkg;
  localparam int unsigned REG_SRC   = 0;
  localparam int unsigned REG_DST   = 1;
  localparam int unsigned REG_SIZE  = 2;
  localparam int unsigned REG_PITCH = 3;
  localparam int unsigned REG_BASE  = 4;
  localparam int unsigned REG_COLOR = 5;
  localparam int unsigned REG_CTRL  = 6;
  localparam int unsigned REG_STAT  = 7;

  localparam logic [3:0] CMD_COPY = 4'd0;
  localparam logic [3:0] CMD_FILL = 4'd1;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_FILL} walk_state_t;

  // Linear byte address of (x, y) on a surface of the given pitch.
  function automatic logic [31:0] pix_addr(input logic [31:0] base,
                                           input logic [15:0] x,
                                           input logic [15:0] y,
                                           input logic [15:0] pitch);
    logic [31:0] row;
    row = {16'd0, y} * {16'd0, pitch};
    return base + row + {16'd0, x};
  endfunction

  // Coordinate stepped by an offset in either direction.
  function automatic logic [15:0] step_coord(input logic [15:0] c,
                                             input logic [15:0] off,
                                             input logic        backward);
    return backward ? (c - off) : (c + off);
  endfunction
endpackage

// File: rtl/blit2d_regs.sv
module blit2d_regs
  import blit2d_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  input  logic        busy,
  input  logic        done,
  output logic [31:0] rdata,
  output logic [31:0] src_xy,
  output logic [31:0] dst_xy,
  output logic [31:0] size_wh,
  output logic [31:0] pitch,
  output logic [31:0] base,
  output logic [7:0]  color,
  output logic        backward,
  output logic [3:0]  cmd,
  output logic        start
);
  logic go_q;
  logic wr_ok;
  logic size_ok;
  logic cmd_ok;

  assign wr_ok   = wr && !busy;
  assign size_ok = (size_wh[31:16] != 16'd0) && (size_wh[15:0] != 16'd0);
  assign cmd_ok  = (wdata[19:16] == CMD_COPY) || (wdata[19:16] == CMD_FILL);
  assign start   = wr_ok && (addr == 3'(REG_CTRL)) && wdata[31] && size_ok && cmd_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_xy   <= '0;
      dst_xy   <= '0;
      size_wh  <= '0;
      pitch    <= '0;
      base     <= '0;
      color    <= '0;
      backward <= 1'b0;
      cmd      <= '0;
      go_q     <= 1'b0;
    end else begin
      if (done) go_q <= 1'b0;
      if (wr_ok) begin
        case (addr)
          3'(REG_SRC):   src_xy  <= wdata;
          3'(REG_DST):   dst_xy  <= wdata;
          3'(REG_SIZE):  size_wh <= wdata;
          3'(REG_PITCH): pitch   <= wdata;
          3'(REG_BASE):  base    <= wdata;
          3'(REG_COLOR): color   <= wdata[7:0];
          3'(REG_CTRL): begin
            backward <= wdata[27];
            cmd      <= wdata[19:16];
            go_q     <= start;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      3'(REG_SRC):   rdata = src_xy;
      3'(REG_DST):   rdata = dst_xy;
      3'(REG_SIZE):  rdata = size_wh;
      3'(REG_PITCH): rdata = pitch;
      3'(REG_BASE):  rdata = base;
      3'(REG_COLOR): rdata = {24'd0, color};
      3'(REG_CTRL):  rdata = {go_q, 3'd0, backward, 7'd0, cmd, 16'd0};
      default:       rdata = {28'd0, busy, 3'd0};
    endcase
  end

  // R8: a write during an operation leaves the geometry untouched
  p_busy_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr) |=> ($stable(src_xy) && $stable(dst_xy) && $stable(size_wh) && $stable(pitch)));
  // R7: completion clears the start bit
  p_done_clears_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !go_q);
  // R7: the start bit reads 1 throughout an operation
  p_go_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> go_q);
endmodule

// File: rtl/blit2d_walker.sv
module blit2d_walker #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          active,
  input  logic [CW-1:0] width,
  input  logic [CW-1:0] height,
  output logic [CW-1:0] xoff,
  output logic [CW-1:0] yoff,
  output logic          last
);
  logic row_end;

  assign row_end = (xoff == width - CW'(1));
  assign last    = row_end && (yoff == height - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      xoff <= '0;
      yoff <= '0;
    end else if (step) begin
      if (row_end) begin
        xoff <= '0;
        yoff <= yoff + CW'(1);
      end else begin
        xoff <= xoff + CW'(1);
      end
    end
  end

  // R3: the offsets never leave the rectangle during an operation
  p_offsets_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ((xoff < width) && (yoff < height)));
  // R3: row order, X wraps to zero only when Y advances
  p_row_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && row_end && !last) |=> ((xoff == '0) && (yoff == $past(yoff) + CW'(1))));
endmodule

// File: rtl/blit2d_engine.sv
module blit2d_engine
  import blit2d_pkg::*;
#(
  parameter int unsigned AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          busy
);
  localparam int unsigned CW = 16;

  walk_state_t st;
  logic [31:0] src_xy, dst_xy, size_wh, pitch, base;
  logic [7:0]  color;
  logic        backward, start, done, step, last;
  logic [3:0]  cmd;
  logic [CW-1:0] xoff, yoff;
  logic [31:0] src_lin, dst_lin;

  assign busy = (st != ST_IDLE);
  assign step = (st == ST_WRITE) || (st == ST_FILL);
  assign done = step && last;

  blit2d_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .done(done), .rdata(reg_rdata),
    .src_xy(src_xy), .dst_xy(dst_xy), .size_wh(size_wh), .pitch(pitch),
    .base(base), .color(color), .backward(backward), .cmd(cmd), .start(start)
  );

  blit2d_walker #(.CW(CW)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(start), .step(step), .active(busy),
    .width(size_wh[31:16]), .height(size_wh[15:0]),
    .xoff(xoff), .yoff(yoff), .last(last)
  );

  assign src_lin = pix_addr(base,
                            step_coord(src_xy[31:16], xoff, backward),
                            step_coord(src_xy[15:0],  yoff, backward),
                            pitch[15:0]);
  assign dst_lin = pix_addr(base,
                            step_coord(dst_xy[31:16], xoff, backward),
                            step_coord(dst_xy[15:0],  yoff, backward),
                            pitch[31:16]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_IDLE:  if (start) st <= (reg_wdata[19:16] == CMD_FILL) ? ST_FILL : ST_READ;
        ST_READ:  st <= ST_WRITE;
        ST_WRITE: st <= last ? ST_IDLE : ST_READ;
        ST_FILL:  if (last) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_en    = busy;
    mem_we    = step;
    mem_addr  = (st == ST_READ) ? src_lin[AW-1:0] : dst_lin[AW-1:0];
    mem_wdata = (st == ST_FILL) ? color : mem_rdata;
  end

  // R5: every source read is followed by a destination write
  p_write_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ) |=> (mem_en && mem_we && (st == ST_WRITE)));
  // R5: the written byte is the one just read
  p_copy_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WRITE) |-> (mem_wdata == mem_rdata));
  // R6: a fill writes the colour byte
  p_fill_color_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FILL) |-> (mem_we && mem_wdata == color));
  // R9: no memory traffic while idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);
  // R2: a start request makes the engine busy on the next edge
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: tb/blit2d_engine_tb.sv
module blit2d_engine_tb;
  localparam int AW = 24;
  localparam int MSZ = 4096;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_en, mem_we, busy;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  logic [7:0] mem [0:MSZ-1];
  logic [7:0] ref_m [0:MSZ-1];
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  blit2d_engine #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[11:0]];
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(input int a, output logic [31:0] d);
    reg_addr = 3'(a);
    #1 d = reg_rdata;
  endtask

  function automatic int lin(int base, int x, int y, int p);
    return (base + y * p + x) & (MSZ - 1);
  endfunction

  // Reference: source snapshot first, then destination writes.
  task automatic ref_apply(input int fill, input int bk, input int sx, input int sy,
                           input int dx, input int dy, input int w, input int h,
                           input int sp, input int dp, input int base, input int col);
    logic [7:0] tmp [0:1023];
    int ox, oy, px, py;
    ox = bk ? sx - (w - 1) : sx; oy = bk ? sy - (h - 1) : sy;
    px = bk ? dx - (w - 1) : dx; py = bk ? dy - (h - 1) : dy;
    for (int j = 0; j < h; j++)
      for (int i = 0; i < w; i++)
        tmp[j*w+i] = ref_m[lin(base, ox+i, oy+j, sp)];
    for (int j = 0; j < h; j++)
      for (int i = 0; i < w; i++)
        ref_m[lin(base, px+i, py+j, dp)] = fill ? 8'(col) : tmp[j*w+i];
  endtask

  task automatic compare_mem(input string req, input string what);
    int bad = -1;
    for (int k = 0; k < MSZ; k++) if (bad < 0 && mem[k] !== ref_m[k]) bad = k;
    tests++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s %s: byte 0x%0h got 0x%0h expected 0x%0h", req, what, bad, mem[bad], ref_m[bad]);
    end
  endtask

  // Programs and runs one operation, returns the number of busy cycles.
  task automatic run_op(input int fill, input int bk, input int sx, input int sy,
                        input int dx, input int dy, input int w, input int h,
                        input int sp, input int dp, input int base, input int col,
                        output int cyc);
    reg_write(0, {16'(sx), 16'(sy)});
    reg_write(1, {16'(dx), 16'(dy)});
    reg_write(2, {16'(w), 16'(h)});
    reg_write(3, {16'(dp), 16'(sp)});
    reg_write(4, 32'(base));
    reg_write(5, 32'(col));
    reg_write(6, {1'b1, 3'd0, 1'(bk), 7'd0, 4'(fill), 16'd0});
    cyc = 0;
    while (busy && cyc < 20000) begin cyc++; @(negedge clk); end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int cyc, seed_dummy;
    seed_dummy = $urandom(32'h5eed);
    for (int k = 0; k < MSZ; k++) begin mem[k] = 8'($urandom); ref_m[k] = mem[k]; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // Reset state
    check("R7", "busy after reset", busy, 0);
    reg_read(7, rd); check("R7", "status after reset", rd, 0);
    reg_read(6, rd); check("R7", "control after reset", rd, 0);
    check("R9", "mem_en after reset", mem_en, 0);

    // R1 register packing and readback
    reg_write(0, 32'h0012_0034); reg_read(0, rd); check("R1", "source corner", rd, 32'h0012_0034);
    reg_write(3, 32'h0040_0030); reg_read(3, rd); check("R1", "pitch", rd, 32'h0040_0030);
    reg_write(5, 32'h0000_00a5); reg_read(5, rd); check("R1", "colour", rd, 32'h0000_00a5);

    // R6 fill, R3 forward addressing
    run_op(1, 0, 0, 0, 5, 3, 7, 4, 64, 64, 0, 8'h3c, cyc);
    ref_apply(1, 0, 0, 0, 5, 3, 7, 4, 64, 64, 0, 8'h3c);
    compare_mem("R6", "fill 7x4"); check("R6", "fill cycles", cyc, 28);
    reg_read(6, rd); check("R7", "start bit cleared", rd[31], 0);

    // R5 forward copy, distinct pitches, nonzero base (R3)
    run_op(0, 0, 2, 1, 10, 30, 5, 3, 64, 48, 64, 0, cyc);
    ref_apply(0, 0, 2, 1, 10, 30, 5, 3, 64, 48, 64, 0);
    compare_mem("R3", "copy with differing pitches"); check("R5", "copy cycles", cyc, 30);

    // R4/R10 overlap, shift right by one on the same row -> backward, corners bottom-right
    run_op(0, 1, 9+5, 10+2, 10+5, 10+2, 6, 3, 64, 64, 0, 0, cyc);
    ref_apply(0, 1, 14, 12, 15, 12, 6, 3, 64, 64, 0, 0);
    compare_mem("R10", "overlap shift right");
    // R4/R10 overlap, shift down
    run_op(0, 1, 20+3, 20+4, 20+3, 22+4, 4, 5, 64, 64, 0, 0, cyc);
    ref_apply(0, 1, 23, 24, 23, 26, 4, 5, 64, 64, 0, 0);
    compare_mem("R10", "overlap shift down");
    // R10 overlap, shift up and left -> forward
    run_op(0, 0, 31, 33, 30, 31, 5, 4, 64, 64, 0, 0, cyc);
    ref_apply(0, 0, 31, 33, 30, 31, 5, 4, 64, 64, 0, 0);
    compare_mem("R10", "overlap shift up");

    // R8 writes during busy, R7 status while running
    reg_write(0, {16'd1, 16'd40}); reg_write(1, {16'd20, 16'd44});
    reg_write(2, {16'd6, 16'd4}); reg_write(3, {16'd64, 16'd64});
    reg_write(4, 0);
    reg_write(6, 32'h8000_0000);
    check("R2", "busy after start", busy, 1);
    reg_read(7, rd); check("R7", "status busy bit", rd[3], 1);
    reg_read(6, rd); check("R7", "control go bit while running", rd[31], 1);
    reg_write(0, 32'h0003_0003); reg_write(3, 32'h0010_0010); reg_write(2, 32'h0001_0001);
    while (busy) @(negedge clk);
    ref_apply(0, 0, 1, 40, 20, 44, 6, 4, 64, 64, 0, 0);
    compare_mem("R8", "copy unaffected by busy writes");
    reg_read(0, rd); check("R8", "source unchanged", rd, {16'd1, 16'd40});
    reg_read(3, rd); check("R8", "pitch unchanged", rd, {16'd64, 16'd64});
    reg_read(7, rd); check("R7", "status clear at end", rd, 0);

    // R9 zero width, zero height, bad command
    reg_write(2, {16'd0, 16'd3}); reg_write(6, 32'h8001_0000);
    check("R9", "zero width busy", busy, 0);
    reg_read(6, rd); check("R9", "zero width go bit", rd[31], 0);
    reg_write(2, {16'd3, 16'd0}); reg_write(6, 32'h8000_0000);
    check("R9", "zero height busy", busy, 0);
    reg_write(2, {16'd3, 16'd3}); reg_write(6, 32'h8002_0000);
    check("R9", "bad command busy", busy, 0);
    compare_mem("R9", "memory untouched");

    // Random mix of fills and overlapping copies
    for (int n = 0; n < 40; n++) begin
      int w, h, sx, sy, dx, dy, p, bk, fl, col;
      w = 1 + $urandom_range(0, 11); h = 1 + $urandom_range(0, 7);
      p = ($urandom_range(0, 1) != 0) ? 64 : 48;
      sx = 4 + $urandom_range(0, 30); sy = 4 + $urandom_range(0, 30);
      dx = sx + $urandom_range(0, 8) - 4; dy = sy + $urandom_range(0, 6) - 3;
      fl = ($urandom_range(0, 3) == 0) ? 1 : 0;
      col = $urandom_range(0, 255);
      bk = ((sy < dy) || (sy == dy && sx < dx)) ? 1 : 0;
      if (bk != 0) begin sx += w - 1; sy += h - 1; dx += w - 1; dy += h - 1; end
      run_op(fl, bk, sx, sy, dx, dy, w, h, p, p, 0, col, cyc);
      ref_apply(fl, bk, sx, sy, dx, dy, w, h, p, p, 0, col);
      compare_mem(fl != 0 ? "R6" : "R10", "random operation");
      check(fl != 0 ? "R6" : "R5", "random busy cycles", cyc, (fl != 0 ? 1 : 2) * w * h);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule